// File: doc/BRIEF.md
# Productive Direction Route Computer

This unit computes the next hop for a packet in a two-dimensional router. It takes the coordinates of the current node and of the destination. For each dimension it works out a travel sign and the remaining hop count. From these it builds a four-bit productive direction vector, which marks every output port that brings the packet closer to its destination. A policy input then chooses one output port, or the local eject port once the packet has arrived.

Four policies are available. Dimension-order finishes x before y. Minimal oblivious draws one productive port using a free-running pseudo-random source. Minimal adaptive takes the productive port whose output queue is shortest. Fully adaptive may send the packet out of an unproductive port when every productive queue is congested. Each such misroute raises a per-packet misroute count, and the count is bounded. A build parameter selects mesh or torus wrap-around. All results are registered and appear one cycle after the request.

Top module: `route_pdv_unit`

## Requirements
- R1: In a mesh, the x sign is 0 (travel +x) when dst_x >= cur_x and 1 otherwise, and hop_x = |dst_x - cur_x|. The y dimension follows the same rule, with +y meaning north.
- R2: In a torus of radix K, let f = (dst - cur) mod K. If f = 0, the sign is 0 and the hop count is 0. If 2f <= K, the sign is 0 and the hop count is f, so an exact half-ring tie goes positive. Otherwise the sign is 1 and the hop count is K - f.
- R3: The vector pdv sets bit 0 (east, +x) when hop_x != 0 and the x sign is 0, bit 1 (west, -x) when hop_x != 0 and the x sign is 1, bit 2 (north, +y) when hop_y != 0 and the y sign is 0, and bit 3 (south, -y) when hop_y != 0 and the y sign is 1.
- R4: When both hop counts are zero, port_sel is 5'b10000 (local eject) under every policy, and mis_out equals mis_in.
- R5: Policy 0 (dimension-order) selects the productive x port if one exists, and the productive y port otherwise.
- R6: Policy 1 (oblivious) selects exactly one productive port, chosen by a 16-bit LFSR that advances every cycle. When two ports are productive, both choices occur over many requests.
- R7: Policy 2 (adaptive) selects the productive port with the smallest queue length. Ties go to the first in the order east, west, north, south.
- R8: Policy 3 (fully adaptive) misroutes when all three of these hold: mis_in < MIS_LIMIT (2); every productive queue exceeds CONG_THR (8); and an allowed unproductive port exists. It then selects the allowed unproductive port with the smallest queue (same tie order) and sets mis_out = mis_in + 1.
- R9: In a mesh, a misroute never selects a port that leaves the grid. If no allowed unproductive port remains, the policy 2 choice is used instead.
- R10: Under policy 3 without a misroute, and under policies 0 to 2, mis_out equals mis_in. Policy 3 then returns the policy 2 choice.
- R11: out_valid and all results are registered one cycle after in_valid. After reset, out_valid and port_sel are zero.
- R12: Whenever out_valid is high, exactly one bit of port_sel is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | Policy: 0 dimension-order, 1 oblivious, 2 adaptive, 3 fully adaptive |
| cur_x | input | CW | Current node x |
| cur_y | input | CW | Current node y |
| dst_x | input | CW | Destination x |
| dst_y | input | CW | Destination y |
| q_len | input | 4*QW | Queue lengths, east in the lowest field, then west, north, south |
| mis_in | input | MW | Misroutes taken so far by this packet |
| out_valid | output | 1 | Result strobe |
| port_sel | output | 5 | One-hot choice: bits 0..3 are E, W, N, S; bit 4 is eject |
| pdv | output | 4 | Productive direction vector |
| sx | output | 1 | x sign |
| sy | output | 1 | y sign |
| hop_x | output | CW | Remaining x hops |
| hop_y | output | CW | Remaining y hops |
| mis_out | output | MW | Updated misroute count |

## Verification
Every result, including port_sel, pdv, the signs, the hop counts and mis_out, passes through exactly one register. Each is therefore due on the first rising edge after the request is presented. The bench drives a request on a falling edge and compares all outputs on the next falling edge, so each vector takes one cycle. In parallel, the LFSR advances on that same edge. For this reason the oblivious choice is checked for membership in pdv rather than against a predicted value.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  typedef enum logic [1:0] {
    POL_DOR  = 2'd0,
    POL_OBLV = 2'd1,
    POL_ADPT = 2'd2,
    POL_FULL = 2'd3
  } policy_e;

  // Output port indices; index 4 is the local eject port
  localparam int P_E   = 0;
  localparam int P_W   = 1;
  localparam int P_N   = 2;
  localparam int P_S   = 3;
  localparam int NPORT = 4;

  // Keep only the least significant set bit of a port mask
  function automatic logic [NPORT-1:0] lowest_bit(input logic [NPORT-1:0] m);
    return m & (~m + NPORT'(1));
  endfunction

endpackage

// File: rtl/rpc_dim_calc.sv
module rpc_dim_calc #(
  parameter int K     = 8,
  parameter bit TORUS = 1'b0,
  parameter int CW    = 3
) (
  input  logic [CW-1:0] cur,
  input  logic [CW-1:0] dst,
  output logic          sgn,
  output logic [CW-1:0] hop,
  output logic          at_lo,
  output logic          at_hi
);
  localparam int CW1 = CW + 1;

  // Forward distance around the ring, (dst - cur) mod K
  function automatic logic [CW:0] ring_fwd(input logic [CW-1:0] c, input logic [CW-1:0] d);
    if (d >= c) return {1'b0, d} - {1'b0, c};
    else        return {1'b0, d} + CW1'(K) - {1'b0, c};
  endfunction

  generate
    if (TORUS) begin : g_torus
      logic [CW:0] fwd;
      always_comb begin
        fwd = ring_fwd(cur, dst);
        if (fwd == '0) begin
          sgn = 1'b0;
          hop = '0;
        end else if ((int'(fwd) * 2) <= K) begin
          sgn = 1'b0;
          hop = CW'(fwd);
        end else begin
          sgn = 1'b1;
          hop = CW'(K - int'(fwd));
        end
      end
    end else begin : g_mesh
      always_comb begin
        if (dst >= cur) begin
          sgn = 1'b0;
          hop = dst - cur;
        end else begin
          sgn = 1'b1;
          hop = cur - dst;
        end
      end
    end
  endgenerate

  assign at_lo = (cur == '0);
  assign at_hi = (cur == CW'(K - 1));

endmodule

// File: rtl/rpc_lfsr.sv
module rpc_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  output logic rnd
);
  logic [15:0] state;
  logic        fb;

  // Taps 16,14,13,11: maximal length
  assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= {state[14:0], fb};
  end

  assign rnd = state[0];

  // R6: the random source never locks up in the all-zero state
  a_r6_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n) state != '0);

endmodule

// File: rtl/rpc_policy.sv
module rpc_policy
  import rpc_pkg::*;
#(
  parameter int QW        = 4,
  parameter int MW        = 2,
  parameter int MIS_LIMIT = 2,
  parameter int CONG_THR  = 8
) (
  input  logic [1:0]          mode,
  input  logic [NPORT-1:0]    pdv,
  input  logic                eject,
  input  logic [NPORT*QW-1:0] q_len,
  input  logic [NPORT-1:0]    exit_ok,
  input  logic                rnd,
  input  logic [MW-1:0]       mis_in,
  output logic [NPORT:0]      pick,
  output logic [MW-1:0]       mis_nxt,
  output logic                misroute
);
  localparam logic [MW-1:0] LIM_V = MW'(MIS_LIMIT);
  localparam logic [QW-1:0] THR_V = QW'(CONG_THR);

  // Shortest queue among the masked ports; a strict compare keeps E,W,N,S priority
  function automatic logic [NPORT-1:0] argmin(input logic [NPORT-1:0] mask,
                                              input logic [NPORT*QW-1:0] q);
    logic [NPORT-1:0] r;
    logic [QW-1:0]    bq;
    logic             any;
    r = '0; bq = '0; any = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      if (mask[i] && (!any || q[i*QW +: QW] < bq)) begin
        r      = '0;
        r[i]   = 1'b1;
        bq     = q[i*QW +: QW];
        any    = 1'b1;
      end
    end
    return r;
  endfunction

  logic [NPORT-1:0] dor_pick, obl_pick, adp_pick, mis_pick, low, high, cand;
  logic             congested;
  policy_e          pol;

  assign pol = policy_e'(mode);

  always_comb begin
    dor_pick = (pdv[P_W:P_E] != '0) ? {2'b00, pdv[P_W:P_E]} : {pdv[P_S:P_N], 2'b00};
    low      = lowest_bit(pdv);
    high     = pdv & ~low;
    obl_pick = (rnd && high != '0) ? high : low;
    adp_pick = argmin(pdv, q_len);
    congested = (pdv != '0);
    for (int i = 0; i < NPORT; i++)
      if (pdv[i] && !(q_len[i*QW +: QW] > THR_V)) congested = 1'b0;
    cand     = ~pdv & exit_ok;
    mis_pick = argmin(cand, q_len);
    misroute = !eject && (pol == POL_FULL) && congested && (cand != '0) && (mis_in < LIM_V);
  end

  always_comb begin
    mis_nxt = misroute ? (mis_in + MW'(1)) : mis_in;
    if (eject) begin
      pick = {1'b1, {NPORT{1'b0}}};
    end else begin
      unique case (pol)
        POL_DOR:  pick = {1'b0, dor_pick};
        POL_OBLV: pick = {1'b0, obl_pick};
        POL_ADPT: pick = {1'b0, adp_pick};
        default:  pick = {1'b0, misroute ? mis_pick : adp_pick};
      endcase
    end
  end

endmodule

// File: rtl/route_pdv_unit.sv
module route_pdv_unit
  import rpc_pkg::*;
#(
  parameter int K         = 8,
  parameter bit TORUS     = 1'b0,
  parameter int QW        = 4,
  parameter int MW        = 2,
  parameter int MIS_LIMIT = 2,
  parameter int CONG_THR  = 8,
  localparam int CW       = (K > 1) ? $clog2(K) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      mode,
  input  logic [CW-1:0]   cur_x,
  input  logic [CW-1:0]   cur_y,
  input  logic [CW-1:0]   dst_x,
  input  logic [CW-1:0]   dst_y,
  input  logic [4*QW-1:0] q_len,
  input  logic [MW-1:0]   mis_in,
  output logic            out_valid,
  output logic [4:0]      port_sel,
  output logic [3:0]      pdv,
  output logic            sx,
  output logic            sy,
  output logic [CW-1:0]   hop_x,
  output logic [CW-1:0]   hop_y,
  output logic [MW-1:0]   mis_out
);
  // Per-dimension sign and distance
  logic          sx_c, sy_c, xlo, xhi, ylo, yhi;
  logic [CW-1:0] hx_c, hy_c;

  rpc_dim_calc #(.K(K), .TORUS(TORUS), .CW(CW)) u_dim_x (
    .cur(cur_x), .dst(dst_x), .sgn(sx_c), .hop(hx_c), .at_lo(xlo), .at_hi(xhi));
  rpc_dim_calc #(.K(K), .TORUS(TORUS), .CW(CW)) u_dim_y (
    .cur(cur_y), .dst(dst_y), .sgn(sy_c), .hop(hy_c), .at_lo(ylo), .at_hi(yhi));

  // Productive direction vector and eject detection
  logic [NPORT-1:0] pdv_c, exit_ok;
  logic             eject_c;

  always_comb begin
    pdv_c      = '0;
    pdv_c[P_E] = (hx_c != '0) && !sx_c;
    pdv_c[P_W] = (hx_c != '0) &&  sx_c;
    pdv_c[P_N] = (hy_c != '0) && !sy_c;
    pdv_c[P_S] = (hy_c != '0) &&  sy_c;
    eject_c    = (hx_c == '0) && (hy_c == '0);
    // Ports that stay on the grid; a ring has no edge
    exit_ok    = TORUS ? {NPORT{1'b1}} : {~ylo, ~yhi, ~xlo, ~xhi};
  end

  logic rnd;
  rpc_lfsr #(.SEED(16'hACE1)) u_lfsr (.clk(clk), .rst_n(rst_n), .rnd(rnd));

  logic [NPORT:0] pick_c;
  logic [MW-1:0]  mis_c;
  logic           misroute_c;

  rpc_policy #(.QW(QW), .MW(MW), .MIS_LIMIT(MIS_LIMIT), .CONG_THR(CONG_THR)) u_policy (
    .mode(mode), .pdv(pdv_c), .eject(eject_c), .q_len(q_len), .exit_ok(exit_ok),
    .rnd(rnd), .mis_in(mis_in), .pick(pick_c), .mis_nxt(mis_c), .misroute(misroute_c));

  // Single result register stage
  logic misroute_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      port_sel   <= '0;
      pdv        <= '0;
      sx         <= 1'b0;
      sy         <= 1'b0;
      hop_x      <= '0;
      hop_y      <= '0;
      mis_out    <= '0;
      misroute_q <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        port_sel   <= pick_c;
        pdv        <= pdv_c;
        sx         <= sx_c;
        sy         <= sy_c;
        hop_x      <= hx_c;
        hop_y      <= hy_c;
        mis_out    <= mis_c;
        misroute_q <= misroute_c;
      end
    end
  end

  a_r11_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r11_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r12_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(port_sel) == 1);
  a_r3_no_opposed: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(pdv[P_E] && pdv[P_W]) && !(pdv[P_N] && pdv[P_S]));
  a_r4_eject_home: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && hop_x == '0 && hop_y == '0 |-> port_sel[NPORT] && pdv == '0);
  a_r7_productive_pick: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !misroute_q && !port_sel[NPORT] |-> (port_sel[NPORT-1:0] & ~pdv) == '0);
  a_r8_misroute_away: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && misroute_q |-> (port_sel[NPORT-1:0] & pdv) == '0 && mis_out != '0);
  a_r10_budget: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> mis_out <= MW'(MIS_LIMIT));

endmodule

// File: tb/route_pdv_unit_bench.sv
module route_pdv_unit_bench;
  localparam int KM = 8, KT = 4, QW = 4, MW = 2, LIM = 2, THR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] mode = '0;
  logic [4*QW-1:0] q_len = '0;
  logic [MW-1:0] mis_in = '0;
  logic [2:0] m_cx = '0, m_cy = '0, m_dx = '0, m_dy = '0;
  logic [1:0] t_cx = '0, t_cy = '0, t_dx = '0, t_dy = '0;

  logic m_ov, m_sx, m_sy, t_ov, t_sx, t_sy;
  logic [4:0] m_sel, t_sel;
  logic [3:0] m_pdv, t_pdv;
  logic [2:0] m_hx, m_hy;
  logic [1:0] t_hx, t_hy;
  logic [MW-1:0] m_mo, t_mo;

  always #10 clk = ~clk;

  route_pdv_unit #(.K(KM), .TORUS(1'b0)) u_route_pdv_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .cur_x(m_cx), .cur_y(m_cy), .dst_x(m_dx), .dst_y(m_dy), .q_len(q_len), .mis_in(mis_in),
    .out_valid(m_ov), .port_sel(m_sel), .pdv(m_pdv), .sx(m_sx), .sy(m_sy),
    .hop_x(m_hx), .hop_y(m_hy), .mis_out(m_mo));

  route_pdv_unit #(.K(KT), .TORUS(1'b1)) u_route_pdv_unit_torus (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .cur_x(t_cx), .cur_y(t_cy), .dst_x(t_dx), .dst_y(t_dy), .q_len(q_len), .mis_in(mis_in),
    .out_valid(t_ov), .port_sel(t_sel), .pdv(t_pdv), .sx(t_sx), .sy(t_sy),
    .hop_x(t_hx), .hop_y(t_hy), .mis_out(t_mo));

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int qv[4];
  int obl_low = 0, obl_high = 0;
  // expected values
  int e_sx, e_sy, e_hx, e_hy, e_pdv, e_sel, e_mis;
  string e_tag;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int argmin(input int mask);
    int best = -1;
    for (int i = 0; i < 4; i++)
      if (mask[i] && (best < 0 || qv[i] < qv[best])) best = i;
    return (best < 0) ? 0 : (1 << best);
  endfunction

  task automatic dim(input int kk, input bit tor, input int c, input int d,
                     output int s, output int h);
    if (!tor) begin
      if (d >= c) begin s = 0; h = d - c; end else begin s = 1; h = c - d; end
    end else begin
      int f = (d - c + kk) % kk;
      if (f == 0) begin s = 0; h = 0; end
      else if (2 * f <= kk) begin s = 0; h = f; end
      else begin s = 1; h = kk - f; end
    end
  endtask

  task automatic model(input int kk, input bit tor, input int cx, input int cy,
                       input int dx, input int dy, input int m, input int mis);
    int ok, cand, cong;
    dim(kk, tor, cx, dx, e_sx, e_hx);
    dim(kk, tor, cy, dy, e_sy, e_hy);
    e_pdv = ((e_hx != 0 && e_sx == 0) ? 1 : 0) | ((e_hx != 0 && e_sx == 1) ? 2 : 0) |
            ((e_hy != 0 && e_sy == 0) ? 4 : 0) | ((e_hy != 0 && e_sy == 1) ? 8 : 0);
    e_mis = mis;
    if (e_hx == 0 && e_hy == 0) begin e_sel = 16; e_tag = "R4"; return; end
    case (m)
      0: begin e_sel = ((e_pdv & 3) != 0) ? (e_pdv & 3) : (e_pdv & 12); e_tag = "R5"; end
      1: begin e_sel = -1; e_tag = "R6"; end
      2: begin e_sel = argmin(e_pdv); e_tag = "R7"; end
      default: begin
        ok = tor ? 15 : (((cx != kk-1) ? 1 : 0) | ((cx != 0) ? 2 : 0) |
                         ((cy != kk-1) ? 4 : 0) | ((cy != 0) ? 8 : 0));
        cand = ~e_pdv & ok & 15;
        cong = 1;
        for (int i = 0; i < 4; i++) if (e_pdv[i] && qv[i] <= THR) cong = 0;
        if (mis < LIM && cong == 1 && cand != 0) begin
          e_sel = argmin(cand); e_mis = mis + 1; e_tag = "R8";
        end else begin
          e_sel = argmin(e_pdv);
          e_tag = (mis < LIM && cong == 1 && (~e_pdv & 15) != 0) ? "R9" : "R10";
        end
      end
    endcase
  endtask

  task automatic run_vec(input bit tor, input int cx, input int cy, input int dx,
                         input int dy, input int m, input int mis);
    int sel, pdvv, sxv, syv, hxv, hyv, mov, ovv;
    string dtag;
    for (int i = 0; i < 4; i++) begin
      qv[i] = (cx * 5 + cy * 3 + dx * 7 + dy + i * 4 + m) % 16;
      q_len[i*QW +: QW] = 4'(qv[i]);
    end
    mode = 2'(m); mis_in = MW'(mis); in_valid = 1'b1;
    if (tor) begin t_cx = 2'(cx); t_cy = 2'(cy); t_dx = 2'(dx); t_dy = 2'(dy); end
    else     begin m_cx = 3'(cx); m_cy = 3'(cy); m_dx = 3'(dx); m_dy = 3'(dy); end
    model(tor ? KT : KM, tor, cx, cy, dx, dy, m, mis);
    @(negedge clk);
    if (tor) begin
      ovv = int'(t_ov); sel = int'(t_sel); pdvv = int'(t_pdv); sxv = int'(t_sx); syv = int'(t_sy);
      hxv = int'(t_hx); hyv = int'(t_hy); mov = int'(t_mo); dtag = "R2";
    end else begin
      ovv = int'(m_ov); sel = int'(m_sel); pdvv = int'(m_pdv); sxv = int'(m_sx); syv = int'(m_sy);
      hxv = int'(m_hx); hyv = int'(m_hy); mov = int'(m_mo); dtag = "R1";
    end
    chk("R11", "out_valid", ovv, 1);
    chk(dtag, "sign/hop", (sxv << 12) | (syv << 8) | (hxv << 4) | hyv,
        (e_sx << 12) | (e_sy << 8) | (e_hx << 4) | e_hy);
    chk("R3", "pdv", pdvv, e_pdv);
    chk("R12", "one-hot", $countones(5'(sel)), 1);
    if (e_sel < 0) begin
      // oblivious: any single productive port
      chk("R6", "pick in pdv", ((sel & ~e_pdv & 31) == 0) ? 1 : 0, 1);
      if ($countones(4'(e_pdv)) == 2) begin
        if ((sel & e_pdv & -e_pdv) != 0) obl_low++; else obl_high++;
      end
    end else begin
      chk(e_tag, "port_sel", sel, e_sel);
    end
    chk((e_tag == "R8") ? "R8" : "R10", "mis_out", mov, e_mis);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "reset out_valid", int'(m_ov), 0);
    chk("R11", "reset port_sel", int'(m_sel), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "idle out_valid", int'(m_ov), 0);
    // mesh sweep, every policy and every coordinate pair
    for (int m = 0; m < 4; m++)
      for (int cx = 0; cx < KM; cx++)
        for (int cy = 0; cy < KM; cy++)
          for (int dx = 0; dx < KM; dx++)
            for (int dy = 0; dy < KM; dy++)
              run_vec(1'b0, cx, cy, dx, dy, m, (cx + cy + dx) % 3);
    // torus sweep with ring wrap and half-ring ties
    for (int m = 0; m < 4; m++)
      for (int cx = 0; cx < KT; cx++)
        for (int cy = 0; cy < KT; cy++)
          for (int dx = 0; dx < KT; dx++)
            for (int dy = 0; dy < KT; dy++)
              run_vec(1'b1, cx, cy, dx, dy, m, (cy + dx + dy) % 3);
    // R9: corner node, both unproductive ports leave the grid, all queues congested
    in_valid = 1'b1; mode = 2'd3; mis_in = '0; q_len = {4{4'd12}};
    m_cx = 3'd0; m_cy = 3'd0; m_dx = 3'd3; m_dy = 3'd3;
    @(negedge clk);
    chk("R9", "corner no misroute", int'(m_sel), 1);
    chk("R9", "corner mis_out", int'(m_mo), 0);
    // R8: same congestion mid-grid misroutes to west (first allowed unproductive port)
    m_cx = 3'd3; m_cy = 3'd3; m_dx = 3'd5; m_dy = 3'd5;
    @(negedge clk);
    chk("R8", "mid-grid misroute", int'(m_sel), 2);
    chk("R8", "mid-grid mis_out", int'(m_mo), 1);
    // R10: budget exhausted falls back to adaptive
    mis_in = 2'd2;
    @(negedge clk);
    chk("R10", "limit fallback", int'(m_sel), 1);
    chk("R10", "limit mis_out", int'(m_mo), 2);
    // R11: dropping the strobe clears out_valid one cycle later
    in_valid = 1'b0;
    @(negedge clk);
    chk("R11", "strobe low", int'(m_ov), 0);
    chk("R6", "both oblivious choices seen", ((obl_low > 0) && (obl_high > 0)) ? 1 : 0, 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule